// File: doc/BRIEF.md
# I2C Master Buffered Transmit Engine

This block is the sending half of an I2C bus master. Software fills a packed buffer of eight 32-bit words (up to 32 bytes), then writes a byte count. Writing the count launches the burst. The engine walks the buffer from byte 0 upward and shifts each byte out most significant bit first. After every byte it samples the acknowledge bit. A clean end of burst, a refused byte, a finished START and a finished STOP each set their own pending flag. Each flag can be routed to a single interrupt line.

The engine never touches the wires itself. It hands one command at a time (START, STOP, write one bit, sample acknowledge) to a bit-level driver. The driver performs the bus timing and pulses a completion strobe. START and STOP are control bits that software sets and clears. A START issued while the bus is still owned after a burst becomes a repeated START. An address-only message is a burst of one byte. Writing STOP together with enable while every interrupt is masked abandons whatever is in flight and releases the bus. This is the path software uses after a timeout.

Top module: `i2cm_tx_engine`

## Requirements
- R1: After reset every register reads 0, `cmd_valid` is 0 and `irq` is 0.
- R2: Buffer word i (register address 8+i) holds byte j in bits 8*j+7:8*j. Byte number 4*i+j is sent in ascending byte order. Each byte is sent as eight write-bit commands (`cmd_op`=2) carrying bit 7 first on `cmd_sda`. The eight bits are followed by one acknowledge-sample command (`cmd_op`=3, `cmd_sda`=1).
- R3: Writing a value from 1 to 32 to the count register (address 3) starts a burst, provided the engine is enabled and idle. The burst sends that many bytes. When the last acknowledge is sampled low, pending bit 2 (transfer done) is set. The values 0 and above 32 start nothing.
- R4: A write to the control register (address 0; bit 0 enable, bit 1 START, bit 2 STOP) that raises the START bit from 0 to 1 with enable set issues exactly one START command (`cmd_op`=0). Its completion sets pending bit 0.
- R5: A write that raises the STOP bit with enable set issues one STOP command (`cmd_op`=1). Its completion sets pending bit 1.
- R6: An acknowledge sample that returns `rsp_sda`=1 (NACK) sets pending bit 3. The remaining bytes of the burst are not sent, and pending bit 2 stays clear.
- R7: A START requested after a burst completes is issued directly, with no STOP command between the last acknowledge sample and the START.
- R8: A one-byte burst (an address byte alone, as in a quick command) sends that single byte and sets pending bit 2.
- R9: Writing the control register with enable and STOP both set while the interrupt enable register (address 1) is 0 abandons the current command at once. No further bytes of the burst are sent, and the next command issued is a STOP.
- R10: `irq` is high exactly when some pending bit (address 2) and the same interrupt enable bit are both 1. Writing 1 to a pending bit clears it.
- R11: While enable is 0, count writes and START/STOP requests produce no commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| cmd_valid | output | 1 | Command presented to the bit driver |
| cmd_op | output | 2 | 0 START, 1 STOP, 2 write bit, 3 sample acknowledge |
| cmd_sda | output | 1 | Bit value for a write-bit command |
| cmd_done | input | 1 | One-cycle pulse: driver finished the command |
| rsp_sda | input | 1 | Sampled SDA, valid with `cmd_done` on an acknowledge sample |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the buffer with random bytes and runs bursts of random length. It also runs directed lengths of 1 and 32, which exercise the word and byte addressing at both ends of the buffer. A NACK placed on a chosen middle byte shows whether the burst is cut short at that point rather than run to the end. A START issued straight after a burst shows whether the engine inserts a stray STOP before a repeated START. A force-idle write made while the driver is deliberately stalled shows whether the in-flight bit is dropped in favour of a STOP. Count values of 0 and 40, and requests made while disabled, must leave the command log unchanged.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_ACK   = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_BIT  = 2'd2,
        ST_ACK  = 2'd3
    } seq_state_e;

    localparam int PB_START  = 0;
    localparam int PB_STOP   = 1;
    localparam int PB_TXDONE = 2;
    localparam int PB_NACK   = 3;
    localparam int NUM_PEND  = 4;
endpackage

// File: rtl/i2cm_txbuf.sv
module i2cm_txbuf #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int BPW    = WORD_W / 8,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int BIDX_W = $clog2(WORDS * BPW),
    localparam int BPW_W  = $clog2(BPW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WIDX_W-1:0] rd_word_idx,
    output logic [WORD_W-1:0] rd_word,
    input  logic [BIDX_W-1:0] rd_byte_idx,
    output logic [7:0]        rd_byte
);
    typedef struct packed {
        logic [WORDS-1:0][WORD_W-1:0] mem;
    } buf_t;

    buf_t buf_d, buf_q;
    logic [WORD_W-1:0] sel_word;

    always_comb begin
        buf_d = buf_q;
        if (wr_en) begin
            buf_d.mem[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    always_comb begin
        rd_word  = buf_q.mem[rd_word_idx];
        sel_word = buf_q.mem[rd_byte_idx[BIDX_W-1:BPW_W]];
        rd_byte  = sel_word[8*int'(rd_byte_idx[BPW_W-1:0]) +: 8];
    end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
#(
    parameter int MAX_BYTES = 32,
    localparam int BIDX_W = $clog2(MAX_BYTES),
    localparam int CNT_W  = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              force_idle,
    input  logic              burst_go,
    input  logic [CNT_W-1:0]  burst_len,
    output logic [BIDX_W-1:0] byte_idx,
    input  logic [7:0]        byte_in,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic              cmd_sda,
    input  logic              cmd_done,
    input  logic              rsp_sda,
    output logic              ev_start,
    output logic              ev_stop,
    output logic              ev_txdone,
    output logic              ev_nack
);
    typedef struct packed {
        seq_state_e        state;
        bus_op_e           op;
        logic [2:0]        bit_idx;
        logic [BIDX_W-1:0] byte_idx;
        logic [CNT_W-1:0]  left;
        logic              req_start;
        logic              req_stop;
        logic              burst_pend;
        logic [CNT_W-1:0]  burst_len;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        ev_start  = 1'b0;
        ev_stop   = 1'b0;
        ev_txdone = 1'b0;
        ev_nack   = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (en) begin
                    if (s_q.req_stop) begin
                        s_d.state    = ST_CMD;
                        s_d.op       = OP_STOP;
                        s_d.req_stop = 1'b0;
                    end else if (s_q.req_start) begin
                        s_d.state     = ST_CMD;
                        s_d.op        = OP_START;
                        s_d.req_start = 1'b0;
                    end else if (s_q.burst_pend) begin
                        s_d.state      = ST_BIT;
                        s_d.bit_idx    = 3'd7;
                        s_d.byte_idx   = '0;
                        s_d.left       = s_q.burst_len;
                        s_d.burst_pend = 1'b0;
                    end
                end
            end
            ST_CMD: begin
                if (cmd_done) begin
                    s_d.state = ST_IDLE;
                    ev_start  = (s_q.op == OP_START);
                    ev_stop   = (s_q.op == OP_STOP);
                end
            end
            ST_BIT: begin
                if (cmd_done) begin
                    if (s_q.bit_idx == 3'd0) s_d.state = ST_ACK;
                    else                     s_d.bit_idx = s_q.bit_idx - 3'd1;
                end
            end
            ST_ACK: begin
                if (cmd_done) begin
                    if (rsp_sda) begin
                        ev_nack   = 1'b1;
                        s_d.state = ST_IDLE;
                    end else if (s_q.left == CNT_W'(1)) begin
                        ev_txdone = 1'b1;
                        s_d.state = ST_IDLE;
                    end else begin
                        s_d.left     = s_q.left - CNT_W'(1);
                        s_d.byte_idx = s_q.byte_idx + BIDX_W'(1);
                        s_d.bit_idx  = 3'd7;
                        s_d.state    = ST_BIT;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase

        if (en && start_req) s_d.req_start = 1'b1;
        if (en && stop_req)  s_d.req_stop  = 1'b1;
        if (en && burst_go && s_q.state == ST_IDLE && !s_q.burst_pend) begin
            s_d.burst_pend = 1'b1;
            s_d.burst_len  = burst_len;
        end

        if (force_idle) begin
            s_d.state      = ST_IDLE;
            s_d.req_stop   = 1'b1;
            s_d.req_start  = 1'b0;
            s_d.burst_pend = 1'b0;
            ev_start       = 1'b0;
            ev_stop        = 1'b0;
            ev_txdone      = 1'b0;
            ev_nack        = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, op: OP_START, default: '0};
        else        s_q <= s_d;
    end

    always_comb begin
        byte_idx  = s_q.byte_idx;
        cmd_valid = (s_q.state != ST_IDLE);
        cmd_sda   = 1'b1;
        unique case (s_q.state)
            ST_CMD:  cmd_op = s_q.op;
            ST_BIT: begin
                cmd_op  = OP_WRITE;
                cmd_sda = byte_in[s_q.bit_idx];
            end
            ST_ACK:  cmd_op = OP_ACK;
            default: cmd_op = OP_START;
        endcase
    end

    // R4: at most one completion event per cycle
    p_one_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_start, ev_stop, ev_txdone, ev_nack}));

    // R2: a presented command is held until the driver completes it
    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done && !force_idle) |=> (cmd_valid && $stable(cmd_op)));

    // R3: transfer done only from an acknowledged sample
    p_txdone_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_txdone |-> (cmd_op == OP_ACK && cmd_done && !rsp_sda));

    // R6: a refused byte halts the burst
    p_nack_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> !cmd_valid);

    // R9: forcing idle drops the command in flight
    p_force_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        force_idle |=> !cmd_valid);

    // R11: nothing starts while disabled
    p_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !en) |=> !cmd_valid);
endmodule

// File: rtl/i2cm_tx_engine.sv
module i2cm_tx_engine
    import i2cm_pkg::*;
#(
    parameter int BUF_WORDS = 8,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic              cmd_sda,
    input  logic              cmd_done,
    input  logic              rsp_sda,
    output logic              irq
);
    localparam int BPW       = WORD_W / 8;
    localparam int MAX_BYTES = BUF_WORDS * BPW;
    localparam int BIDX_W    = $clog2(MAX_BYTES);
    localparam int CNT_W     = $clog2(MAX_BYTES + 1);
    localparam int WIDX_W    = $clog2(BUF_WORDS);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(3);
    localparam int BUF_BASE = 8;

    typedef struct packed {
        logic                en;
        logic                start;
        logic                stop;
        logic [NUM_PEND-1:0] ien;
        logic [NUM_PEND-1:0] pend;
        logic [CNT_W-1:0]    cnt;
    } regs_t;

    regs_t r_d, r_q;

    logic wr_ctrl, wr_cnt, wr_buf, en_now;
    logic start_pulse, stop_pulse, force_idle, burst_go;
    logic ev_start, ev_stop, ev_txdone, ev_nack;
    logic [BIDX_W-1:0] byte_idx;
    logic [7:0]        byte_val;
    logic [WORD_W-1:0] buf_word;

    always_comb begin
        wr_ctrl     = reg_wr && (reg_addr == A_CTRL);
        wr_cnt      = reg_wr && (reg_addr == A_CNT);
        wr_buf      = reg_wr && (int'(reg_addr) >= BUF_BASE);
        en_now      = wr_ctrl ? reg_wdata[0] : r_q.en;
        start_pulse = wr_ctrl && reg_wdata[1] && !r_q.start;
        stop_pulse  = wr_ctrl && reg_wdata[2] && !r_q.stop;
        force_idle  = wr_ctrl && reg_wdata[0] && reg_wdata[2] && (r_q.ien == '0);
        burst_go    = wr_cnt && (reg_wdata != '0) && (reg_wdata <= WORD_W'(MAX_BYTES));
    end

    always_comb begin
        r_d = r_q;
        if (wr_ctrl) begin
            r_d.en    = reg_wdata[0];
            r_d.start = reg_wdata[1];
            r_d.stop  = reg_wdata[2];
        end
        if (reg_wr && reg_addr == A_IEN) r_d.ien = reg_wdata[NUM_PEND-1:0];
        if (wr_cnt) r_d.cnt = reg_wdata[CNT_W-1:0];
        if (reg_wr && reg_addr == A_PEND) r_d.pend = r_q.pend & ~reg_wdata[NUM_PEND-1:0];
        if (ev_start)  r_d.pend[PB_START]  = 1'b1;
        if (ev_stop)   r_d.pend[PB_STOP]   = 1'b1;
        if (ev_txdone) r_d.pend[PB_TXDONE] = 1'b1;
        if (ev_nack)   r_d.pend[PB_NACK]   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) >= BUF_BASE) begin
            reg_rdata = buf_word;
        end else begin
            unique case (reg_addr)
                A_CTRL:  reg_rdata[2:0] = {r_q.stop, r_q.start, r_q.en};
                A_IEN:   reg_rdata[NUM_PEND-1:0] = r_q.ien;
                A_PEND:  reg_rdata[NUM_PEND-1:0] = r_q.pend;
                A_CNT:   reg_rdata[CNT_W-1:0] = r_q.cnt;
                default: reg_rdata = '0;
            endcase
        end
        irq = |(r_q.pend & r_q.ien);
    end

    i2cm_txbuf #(.WORDS(BUF_WORDS), .WORD_W(WORD_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_buf),
        .wr_idx      (reg_addr[WIDX_W-1:0]),
        .wr_data     (reg_wdata),
        .rd_word_idx (reg_addr[WIDX_W-1:0]),
        .rd_word     (buf_word),
        .rd_byte_idx (byte_idx),
        .rd_byte     (byte_val)
    );

    i2cm_seq #(.MAX_BYTES(MAX_BYTES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_now),
        .start_req  (start_pulse),
        .stop_req   (stop_pulse),
        .force_idle (force_idle),
        .burst_go   (burst_go),
        .burst_len  (reg_wdata[CNT_W-1:0]),
        .byte_idx   (byte_idx),
        .byte_in    (byte_val),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_sda    (cmd_sda),
        .cmd_done   (cmd_done),
        .rsp_sda    (rsp_sda),
        .ev_start   (ev_start),
        .ev_stop    (ev_stop),
        .ev_txdone  (ev_txdone),
        .ev_nack    (ev_nack)
    );

    // R10: a write of 1 clears the transfer-done flag unless it is set again
    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_PEND && reg_wdata[PB_TXDONE] && !ev_txdone)
        |=> !r_q.pend[PB_TXDONE]);

    // R3: transfer-done flag rises only on a sequencer completion
    p_txdone_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.pend[PB_TXDONE]) |-> $past(ev_txdone));
endmodule

// File: tb/tb_i2cm_tx_engine.sv
module tb_i2cm_tx_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic        cmd_sda;
    logic        cmd_done = 1'b0;
    logic        rsp_sda = 1'b1;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [1:0] log_op [0:4095];
    logic       log_sda[0:4095];
    int  log_n = 0;
    int  ack_cnt = 0;
    int  nack_at = -1;
    int  stall_lat = 0;
    logic [7:0] tbuf [0:31];

    always #5 clk = ~clk;

    i2cm_tx_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_sda(cmd_sda), .cmd_done(cmd_done),
        .rsp_sda(rsp_sda), .irq(irq)
    );

    // bit-level driver model: logs each completed command
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid) begin
                logic [1:0] op;
                logic       sda;
                bit         ok;
                int         lat;
                op  = cmd_op;
                sda = cmd_sda;
                ok  = 1;
                lat = (stall_lat != 0) ? stall_lat : 1 + int'($urandom % 3);
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    if (!cmd_valid || cmd_op != op) begin
                        ok = 0;
                        break;
                    end
                end
                if (ok) begin
                    log_op[log_n]  = op;
                    log_sda[log_n] = sda;
                    log_n++;
                    rsp_sda = (op == 2'd3 && ack_cnt == nack_at) ? 1'b1 : (op == 2'd3 ? 1'b0 : 1'b1);
                    if (op == 2'd3) ack_cnt++;
                    cmd_done = 1'b1;
                    @(negedge clk);
                    cmd_done = 1'b0;
                    rsp_sda  = 1'b1;
                end
            end
        end
    end

    task automatic chk(input bit cond, input string tag, input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_pend(input int b, output bit got);
        logic [31:0] v;
        got = 0;
        for (int i = 0; i < 5000; i++) begin
            reg_read(4'd2, v);
            if (v[b]) begin
                got = 1;
                break;
            end
        end
    endtask

    task automatic load_random();
        for (int w = 0; w < 8; w++) begin
            logic [31:0] word;
            word = $urandom;
            for (int j = 0; j < 4; j++) tbuf[4*w+j] = word[8*j +: 8];
            reg_write(4'(8 + w), word);
        end
    endtask

    // expected command at entry e of a burst (R2 encoding)
    function automatic logic [2:0] exp_entry(input int e);
        int k;
        int r;
        k = e / 9;
        r = e % 9;
        if (r < 8) return {2'd2, tbuf[k][7-r]};
        return {2'd3, 1'b1};
    endfunction

    task automatic check_log(input int base, input int nbytes, input string tag);
        bit good;
        int bad;
        good = (log_n - base == nbytes * 9);
        bad = -1;
        for (int e = 0; e < nbytes * 9 && good; e++) begin
            if ({log_op[base+e], log_sda[base+e]} != exp_entry(e)) begin
                good = 0;
                bad = e;
            end
        end
        if (bad >= 0)
            chk(good, tag, {log_op[base+bad], log_sda[base+bad]}, exp_entry(bad));
        else
            chk(good, tag, log_n - base, nbytes * 9);
    endtask

    task automatic run_burst(input int n, input string tag);
        int base;
        bit got;
        base = log_n;
        ack_cnt = 0;
        reg_write(4'd3, n);
        wait_pend(2, got);
        chk(got, {tag, " done flag"}, got, 1);
        check_log(base, n, tag);
        reg_write(4'd2, 32'hF);
    endtask

    initial begin
        logic [31:0] v;
        bit got;
        int base;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(4'd0, v);  chk(v == 0, "R1 ctrl", v, 0);
        reg_read(4'd2, v);  chk(v == 0, "R1 pend", v, 0);
        reg_read(4'd9, v);  chk(v == 0, "R1 buffer", v, 0);
        chk(cmd_valid == 0 && irq == 0, "R1 outputs", {cmd_valid, irq}, 0);

        // R11 disabled: no commands
        load_random();
        reg_write(4'd3, 4);
        reg_write(4'd0, 32'h2);
        repeat (40) @(negedge clk);
        chk(log_n == 0, "R11 disabled no commands", log_n, 0);
        reg_write(4'd0, 32'h0);

        // R4 START
        reg_write(4'd0, 32'h1);
        reg_write(4'd0, 32'h3);
        wait_pend(0, got);
        chk(got && log_n == 1 && log_op[0] == 2'd0, "R4 start", log_op[0], 0);
        reg_write(4'd0, 32'h1);
        reg_write(4'd2, 32'h1);
        reg_read(4'd2, v);
        chk(v == 0, "R10 w1c clear", v, 0);

        // R2/R3 directed and random bursts
        load_random();
        run_burst(32, "R2 full buffer");
        load_random();
        run_burst(5, "R3 five bytes");
        for (int t = 0; t < 5; t++) begin
            load_random();
            run_burst(1 + int'($urandom % 32), "R3 random burst");
        end

        // R8 quick command: address byte only
        tbuf[0] = 8'hA0;
        reg_write(4'd8, 32'h000000A0);
        run_burst(1, "R8 address only");

        // R7 repeated START straight after a burst
        base = log_n;
        reg_write(4'd0, 32'h3);
        wait_pend(0, got);
        chk(got && log_n == base + 1 && log_op[base] == 2'd0 && log_op[base-1] == 2'd3,
            "R7 repeated start no stop", log_op[base], 0);
        reg_write(4'd0, 32'h1);
        reg_write(4'd2, 32'hF);

        // R6 NACK on third byte of five
        load_random();
        base = log_n;
        ack_cnt = 0;
        nack_at = 2;
        reg_write(4'd3, 5);
        wait_pend(3, got);
        repeat (30) @(negedge clk);
        nack_at = -1;
        chk(got && log_n - base == 27, "R6 burst cut after nack", log_n - base, 27);
        reg_read(4'd2, v);
        chk(v[3:2] == 2'b10, "R6 nack flag without done", v[3:2], 2);
        reg_write(4'd2, 32'hF);

        // R5 STOP
        base = log_n;
        reg_write(4'd0, 32'h5);
        wait_pend(1, got);
        chk(got && log_n == base + 1 && log_op[base] == 2'd1, "R5 stop", log_op[base], 1);
        reg_write(4'd0, 32'h1);
        reg_write(4'd2, 32'hF);

        // R3 out-of-range counts ignored
        base = log_n;
        reg_write(4'd3, 0);
        repeat (30) @(negedge clk);
        chk(log_n == base, "R3 count 0 ignored", log_n - base, 0);
        reg_write(4'd3, 40);
        repeat (30) @(negedge clk);
        chk(log_n == base, "R3 count 40 ignored", log_n - base, 0);

        // R10 interrupt routing
        reg_write(4'd1, 32'h4);
        load_random();
        run_burst(2, "R10 burst");
        chk(irq == 0, "R10 irq low after clear", irq, 0);
        reg_write(4'd3, 3);
        wait_pend(2, got);
        @(negedge clk);
        chk(irq == 1, "R10 irq with enabled flag", irq, 1);
        reg_write(4'd1, 32'h0);
        @(negedge clk);
        chk(irq == 0, "R10 irq masked", irq, 0);
        reg_write(4'd2, 32'hF);

        // R9 force idle during a stalled burst
        load_random();
        stall_lat = 20;
        base = log_n;
        reg_write(4'd3, 4);
        repeat (70) @(negedge clk);
        reg_write(4'd0, 32'h5);
        wait_pend(1, got);
        stall_lat = 0;
        repeat (60) @(negedge clk);
        chk(got && log_op[log_n-1] == 2'd1, "R9 stop after force", log_op[log_n-1], 1);
        chk(log_n - base < 10, "R9 burst abandoned", log_n - base, 4);
        reg_read(4'd2, v);
        chk(v[2] == 0, "R9 no done flag", v[2], 0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule